// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Per-Line Bypass

This block gathers up to 32 level-sensitive interrupt lines and turns them into a small set of interrupt outputs for a parent controller. Every line first passes through a two-flop synchronizer. Software sees the synchronized levels in a read-only status word. It gates lines through a single read/write enable word. No set or clear shortcut registers exist, so software changes enable bits only by reading the whole word, modifying it and writing it back.

Each aggregated output has its own fixed 32-bit map mask. The output rises when any line it selects is high, enabled, connected and not forwarded. A separate forward mask picks lines, typically serial-port interrupts, that skip the enable word completely. Each forwarded line drives its own dedicated output, so the parent sees the line as if this block were absent. A connect mask marks the bit positions that have a real line behind them. The other positions read as zero and never raise anything.

The register port is a plain synchronous bus. A small state machine has two states. In `BUS_IDLE` no read response is pending. In `BUS_RESP` the read data is presented. On a read request, the transition `IDLE->RESP` (or `RESP->RESP` for back-to-back reads) captures the data. The transition `RESP->IDLE` is taken when no new read arrives. A write is applied in either state and leads to `BUS_IDLE`.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, the enable word is 0x00000000 and every aggregated and forwarded output is low.
- R2: Byte address 0x0 holds the enable word. A write stores all 32 bits as given. A later read at 0x0 returns exactly those bits.
- R3: A read at byte address 0x4 returns the synchronized line levels ANDed with the connect mask (default 0x00000FFF). Unconnected positions read 0.
- R4: A write to address 0x4 changes neither the enable word nor the status word.
- R5: Output `agg_irq[k]` is the registered OR of level & enable & map_k & ~forward & connect. With the default parameters, map_0 = 0xEB8 and map_1 = 0x140.
- R6: For each line i in the forward mask (default 0x7), `fwd_irq[i]` follows the line level whatever the enable word holds. Such a line never contributes to any `agg_irq` bit.
- R7: A line at an unconnected position never raises any output, even when its enable bit is set.
- R8: `fwd_irq` bits outside the forward mask, or at unconnected positions, stay 0.
- R9: `bus_rvalid` is high for exactly the one cycle after each read request, and that cycle carries the data. Addresses other than 0x0 and 0x4 read as 0 and ignore writes.
- R10: A line change driven before rising edge n appears on the outputs after edge n+2. A write to the enable word accepted at edge n shows on `agg_irq` after edge n+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | LINE_W | Asynchronous level interrupt lines |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | LINE_W | Write data |
| bus_rdata | output | LINE_W | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| agg_irq | output | NUM_AGG | Aggregated outputs toward the parent |
| fwd_irq | output | LINE_W | Per-line bypass outputs |

## Verification
The bench builds the block with its default parameters. These give two aggregated outputs with masks 0xEB8 and 0x140, forward mask 0x7 and twelve connected lines. With these values, forwarded lines, lines mapped to each output and unconnected positions all occur at once. Single-line patterns can therefore tell the two outputs apart. All-ones patterns can show that bypassed and unconnected lines stay out of the aggregated result. The same configuration lets the bench count edges to confirm the three-edge input latency and the two-edge enable latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int unsigned ENABLE_OFFSET = 0;
    localparam int unsigned STATUS_OFFSET = 4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // Two flops per line to settle metastability.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1_q;
        logic stage2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= async_in[i];
                stage2_q <= stage1_q;
            end
        end

        assign sync_out[i] = stage2_q;
    end

endmodule

// File: rtl/irq_reg_bus.sv
module irq_reg_bus
    import irq_agg_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [WIDTH-1:0]  status,
    output logic [WIDTH-1:0]  rdata,
    output logic              rvalid,
    output logic [WIDTH-1:0]  enable
);

    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(ENABLE_OFFSET);
    localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(STATUS_OFFSET);

    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [WIDTH-1:0] rdata_q;
    logic [WIDTH-1:0] rdata_d;
    logic [WIDTH-1:0] enable_q;
    logic [WIDTH-1:0] enable_d;
    logic             rd_req;
    logic             wr_en_hit;

    assign rd_req    = req && !we;
    assign wr_en_hit = req && we && (addr == EN_ADDR);

    // Next-state and data capture.
    always_comb begin
        state_d  = state_q;
        rdata_d  = rdata_q;
        enable_d = enable_q;
        if (wr_en_hit) begin
            enable_d = wdata;
        end
        unique case (state_q)
            BUS_IDLE: begin
                if (rd_req) begin
                    state_d = BUS_RESP;
                end
            end
            BUS_RESP: begin
                if (!rd_req) begin
                    state_d = BUS_IDLE;
                end
            end
            default: state_d = BUS_IDLE;
        endcase
        if (rd_req) begin
            if (addr == EN_ADDR) begin
                rdata_d = enable_q;
            end else if (addr == ST_ADDR) begin
                rdata_d = status;
            end else begin
                rdata_d = '0;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= BUS_IDLE;
            rdata_q  <= '0;
            enable_q <= '0;
        end else begin
            state_q  <= state_d;
            rdata_q  <= rdata_d;
            enable_q <= enable_d;
        end
    end

    // Outputs.
    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                rvalid = 1'b0;
            end
            BUS_RESP: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            default: rvalid = 1'b0;
        endcase
        enable = enable_q;
    end

endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int unsigned               WIDTH     = 32,
    parameter int unsigned               NUM_AGG   = 2,
    parameter logic [NUM_AGG*WIDTH-1:0]  MAP_MASKS = '0,
    parameter logic [WIDTH-1:0]          FWD_MASK  = '0,
    parameter logic [WIDTH-1:0]          CONN_MASK = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   level,
    input  logic [WIDTH-1:0]   enable,
    output logic [NUM_AGG-1:0] agg_out,
    output logic [WIDTH-1:0]   fwd_out
);

    localparam logic [WIDTH-1:0] AGG_ELIGIBLE = CONN_MASK & ~FWD_MASK;
    localparam logic [WIDTH-1:0] FWD_ELIGIBLE = CONN_MASK & FWD_MASK;

    logic [WIDTH-1:0] gated;
    assign gated = level & enable & AGG_ELIGIBLE;

    for (genvar k = 0; k < NUM_AGG; k++) begin : g_agg
        localparam logic [WIDTH-1:0] SEL = MAP_MASKS[k*WIDTH +: WIDTH];
        logic hit;
        assign hit = |(gated & SEL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                agg_out[k] <= 1'b0;
            end else begin
                agg_out[k] <= hit;
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_fwd
        if (FWD_ELIGIBLE[i]) begin : g_on
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fwd_out[i] <= 1'b0;
                end else begin
                    fwd_out[i] <= level[i];
                end
            end
        end else begin : g_off
            assign fwd_out[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
    parameter int unsigned               LINE_W    = 32,
    parameter int unsigned               ADDR_W    = 4,
    parameter int unsigned               NUM_AGG   = 2,
    parameter logic [NUM_AGG*LINE_W-1:0] MAP_MASKS = {32'h0000_0140, 32'h0000_0EB8},
    parameter logic [LINE_W-1:0]         FWD_MASK  = 32'h0000_0007,
    parameter logic [LINE_W-1:0]         CONN_MASK = 32'h0000_0FFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  irq_in,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [LINE_W-1:0]  bus_wdata,
    output logic [LINE_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic [NUM_AGG-1:0] agg_irq,
    output logic [LINE_W-1:0]  fwd_irq
);

    logic [LINE_W-1:0] sync_lvl;
    logic [LINE_W-1:0] status_w;
    logic [LINE_W-1:0] en_q;

    irq_sync #(.WIDTH(LINE_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_lvl)
    );

    assign status_w = sync_lvl & CONN_MASK;

    irq_reg_bus #(.WIDTH(LINE_W), .ADDR_W(ADDR_W)) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .status (status_w),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .enable (en_q)
    );

    irq_route #(
        .WIDTH     (LINE_W),
        .NUM_AGG   (NUM_AGG),
        .MAP_MASKS (MAP_MASKS),
        .FWD_MASK  (FWD_MASK),
        .CONN_MASK (CONN_MASK)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (status_w),
        .enable  (en_q),
        .agg_out (agg_irq),
        .fwd_out (fwd_irq)
    );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned       LINE_W    = 32,
    parameter int unsigned       ADDR_W    = 4,
    parameter int unsigned       NUM_AGG   = 2,
    parameter logic [LINE_W-1:0] FWD_MASK  = '0,
    parameter logic [LINE_W-1:0] CONN_MASK = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [LINE_W-1:0]  bus_wdata,
    input logic               bus_rvalid,
    input logic [NUM_AGG-1:0] agg_irq,
    input logic [LINE_W-1:0]  fwd_irq,
    input logic [LINE_W-1:0]  en_q
);

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R9
    no_spur_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(0)) |=> (en_q == $past(bus_wdata)));

    // R4
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(4)) |=> $stable(en_q));

    // R5
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> (agg_irq == '0));

    // R8
    fwd_confined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_irq & ~(FWD_MASK & CONN_MASK)) == '0);

endmodule

bind irq_agg_top irq_agg_chk #(
    .LINE_W    (LINE_W),
    .ADDR_W    (ADDR_W),
    .NUM_AGG   (NUM_AGG),
    .FWD_MASK  (FWD_MASK),
    .CONN_MASK (CONN_MASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .agg_irq    (agg_irq),
    .fwd_irq    (fwd_irq),
    .en_q       (en_q)
);

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  agg_irq;
    logic [31:0] fwd_irq;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #2 clk = ~clk;

    irq_agg_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .agg_irq    (agg_irq),
        .fwd_irq    (fwd_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: push the expected response, then issue the read.
    task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        @(negedge clk);
        sb_q.push_back(it);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic set_lines(input logic [31:0] v);
        @(negedge clk);
        irq_in = v;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop and compare every read response.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 actual=unexpected_rvalid expected=none");
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rmw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 agg", {30'd0, agg_irq}, 32'h0);
        check("R1 fwd", fwd_irq, 32'h0);
        bus_read(4'h0, 32'h0, "R1 enable");

        // All lines high, nothing enabled
        set_lines(32'hFFFF_FFFF);
        check("R5 agg disabled", {30'd0, agg_irq}, 32'h0);
        check("R6 fwd ungated", fwd_irq, 32'h0000_0007);
        check("R8 fwd confined", fwd_irq & ~32'h7, 32'h0);
        bus_read(4'h4, 32'h0000_0FFF, "R3 status conn");

        // Enable everything
        bus_write(4'h0, 32'hFFFF_FFFF);
        bus_read(4'h0, 32'hFFFF_FFFF, "R2 enable rd");
        repeat (2) @(negedge clk);
        check("R5 agg both", {30'd0, agg_irq}, 32'h3);

        // Only forwarded lines
        set_lines(32'h0000_0007);
        check("R6 no agg from fwd", {30'd0, agg_irq}, 32'h0);
        check("R6 fwd lines", fwd_irq, 32'h0000_0007);

        // Only unconnected lines
        set_lines(32'hFFFF_F000);
        check("R7 agg", {30'd0, agg_irq}, 32'h0);
        check("R7 fwd", fwd_irq, 32'h0);
        bus_read(4'h4, 32'h0, "R7 status");

        // Single mapped lines
        set_lines(32'h0000_0040);
        check("R5 line6 -> out1", {30'd0, agg_irq}, 32'h2);
        check("R8 line6 not fwd", fwd_irq, 32'h0);
        set_lines(32'h0000_0200);
        check("R5 line9 -> out0", {30'd0, agg_irq}, 32'h1);
        bus_read(4'h4, 32'h0000_0200, "R3 status line9");

        // Read-modify-write to drop line 9
        rmw = 32'hFFFF_FFFF & ~32'h0000_0200;
        bus_write(4'h0, rmw);
        repeat (2) @(negedge clk);
        check("R5 line9 gated", {30'd0, agg_irq}, 32'h0);
        bus_read(4'h0, rmw, "R2 rmw");

        // Status write ignored
        bus_write(4'h4, 32'h0);
        bus_read(4'h0, rmw, "R4 enable kept");
        bus_read(4'h4, 32'h0000_0200, "R4 status kept");

        // Unmapped address
        bus_write(4'h8, 32'h0);
        bus_read(4'h8, 32'h0, "R9 unmapped");
        bus_read(4'h0, rmw, "R9 unmapped write ignored");

        // Forward independent of enable
        bus_write(4'h0, 32'h0);
        set_lines(32'h0000_0005);
        check("R6 fwd with en=0", fwd_irq, 32'h0000_0005);

        // R10 latency
        bus_write(4'h0, 32'hFFFF_FFFF);
        set_lines(32'h0);
        @(negedge clk);
        irq_in = 32'h0000_0008;
        repeat (2) @(negedge clk);
        check("R10 not yet", {30'd0, agg_irq}, 32'h0);
        @(negedge clk);
        check("R10 after 3 edges", {30'd0, agg_irq}, 32'h1);
        bus_write(4'h0, 32'h0);
        @(negedge clk);
        check("R10 enable drop", {30'd0, agg_irq}, 32'h0);

        repeat (4) @(negedge clk);
        check("R9 queue drained", 32'(sb_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule